// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Service Request

This block sits between one serial channel's receiver and the host. Each time the receiver finishes a character, it offers the data byte together with its error flags. The block stores the byte and the flags as one entry, in arrival order, in a queue of eight entries. The host sees the oldest entry on its read port at all times. It takes that entry by pulsing a pop request, which retires the data and the status together.

A level-sensitive service request tells the host when the queue needs attention. It is high while the number of stored characters is at or above a threshold taken from a 4-bit configuration field, and it falls again once host reads bring the fill level below that threshold. Characters keep arriving after the request rises, so the host may find more entries than the threshold when it responds.

Overrun is decided at the moment of insertion. A character that arrives while every entry is occupied, with no pop in the same cycle, is discarded. The newest stored entry is then marked with an overrun flag, which the host sees when that entry reaches the read port.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the fill count is 0, the service request is low, and pop_data and pop_stat are zero.
- R2: Each accepted character is stored with its 3 error flags as one entry. Entries leave in arrival order. pop_data shows the oldest byte, and pop_stat[2:0] shows that entry's error flags.
- R3: The fill count rises by one for each accepted character and falls by one for each pop of a non-empty queue. A push and a pop in the same cycle on a non-empty queue leave the count unchanged.
- R4: A pop request on an empty queue has no effect. While the queue is empty, pop_data and pop_stat read as zero.
- R5: A threshold field value of 0, or any value above 8, acts as a threshold of 8. Values 1 to 8 are used as given.
- R6: svc_req is high exactly while the fill count is at or above the effective threshold. It falls as soon as pops bring the count below it.
- R7: A character offered while the count is 8 and no pop is requested is discarded, and the count stays 8.
- R8: Discarding a character sets pop_stat[3] (overrun) on the most recently stored entry only. The flag is visible when that entry is at the read port and is gone once the entry is popped. Newly written entries start with the flag clear.
- R9: When the queue is full, a push and a pop in the same cycle are both honoured: the offered character is stored and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver offers a character this cycle |
| rx_data | input | 8 | Offered character byte |
| rx_err | input | 3 | Error flags of the offered character |
| thresh_cfg | input | 4 | Service-request threshold field |
| pop_req | input | 1 | Host retires the head entry |
| pop_data | output | 8 | Byte of the head entry, zero when empty |
| pop_stat | output | 4 | Head entry status: bit 3 overrun, bits 2:0 error flags |
| fill_count | output | 4 | Number of stored entries, 0 to 8 |
| svc_req | output | 1 | Level service request |

## Verification
On every cycle the assertions check several things: the count stays within bounds, the request level agrees with the count and the clamped threshold, the read port is zero while empty, a pop on an empty queue changes nothing, and a push on a full queue without a pop leaves the count pinned at eight. Some behaviour only the bench scenarios can show: that bytes and flags come back in order and still paired, that the overrun mark lands on the newest entry and no other, and that it disappears with that entry. The bench shows these by draining the queue against a reference model after random and directed traffic.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;
    localparam int STAT_W = ERR_W + 1;

    typedef struct packed {
        logic              ovr;
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_idx_o,
    output logic          mark_en_o,
    output logic [AW-1:0] mark_idx_o,
    output logic [AW-1:0] rd_idx_o,
    output logic          nonempty_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  empty, full, do_pop, do_push, drop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && !empty;
        do_push = push_i && (!full || do_pop);
        drop    = push_i && full && !do_pop;
        if (do_push) st_d.wr = ptr_inc(st_q.wr);
        if (do_pop)  st_d.rd = ptr_inc(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o    = do_push;
    assign wr_idx_o   = st_q.wr;
    assign mark_en_o  = drop;
    assign mark_idx_o = (st_q.wr == '0) ? AW'(DEPTH - 1) : st_q.wr - 1'b1;
    assign rd_idx_o   = st_q.rd;
    assign nonempty_o = !empty;
    assign count_o    = st_q.cnt;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ERR_W-1:0]  wr_err_i,
    input  logic              mark_en_i,
    input  logic [AW-1:0]     mark_idx_i,
    input  logic [AW-1:0]     rd_idx_i,
    input  logic              rd_valid_i,
    output rxq_entry_t        rd_entry_o
);
    logic [DEPTH-1:0][ENTRY_W-1:0] slots_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rxq_entry_t slot_q, slot_d;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && (wr_idx_i == AW'(g))) begin
                slot_d.data = wr_data_i;
                slot_d.err  = wr_err_i;
                slot_d.ovr  = 1'b0;
            end
            if (mark_en_i && (mark_idx_i == AW'(g))) begin
                slot_d.ovr = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slots_flat[g] = slot_q;
    end

    assign rd_entry_o = rd_valid_i ? rxq_entry_t'(slots_flat[rd_idx_i]) : '0;
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
    parameter int DEPTH = 8,
    parameter int TH_W  = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [TH_W-1:0] cfg_i,
    input  logic [CW-1:0]   count_i,
    output logic            req_o
);
    int level;

    always_comb begin
        if ((cfg_i == '0) || (int'(cfg_i) > DEPTH)) level = DEPTH;
        else                                        level = int'(cfg_i);
        req_o = (int'(count_i) >= level);
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TH_W  = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic [TH_W-1:0]   thresh_cfg,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [STAT_W-1:0] pop_stat,
    output logic [CW-1:0]     fill_count,
    output logic              svc_req
);
    logic          wr_en, mark_en, nonempty;
    logic [AW-1:0] wr_idx, mark_idx, rd_idx;
    rxq_entry_t    head;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_valid),
        .pop_i      (pop_req),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .mark_en_o  (mark_en),
        .mark_idx_o (mark_idx),
        .rd_idx_o   (rd_idx),
        .nonempty_o (nonempty),
        .count_o    (fill_count)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (rx_data),
        .wr_err_i   (rx_err),
        .mark_en_i  (mark_en),
        .mark_idx_i (mark_idx),
        .rd_idx_i   (rd_idx),
        .rd_valid_i (nonempty),
        .rd_entry_o (head)
    );

    rxq_thresh #(.DEPTH(DEPTH), .TH_W(TH_W)) u_thresh (
        .cfg_i   (thresh_cfg),
        .count_i (fill_count),
        .req_o   (svc_req)
    );

    assign pop_data = head.data;
    assign pop_stat = {head.ovr, head.err};
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 8,
    parameter int TH_W  = 4,
    parameter int DW    = 8,
    parameter int SW    = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          pop_req,
    input logic [TH_W-1:0] thresh_cfg,
    input logic [CW-1:0] fill_count,
    input logic          svc_req,
    input logic [DW-1:0] pop_data,
    input logic [SW-1:0] pop_stat
);
    function automatic int chk_level(input logic [TH_W-1:0] c);
        int v;
        v = int'(c);
        return ((v == 0) || (v > DEPTH)) ? DEPTH : v;
    endfunction

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH); // R3

    AST_SVC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req == (int'(fill_count) >= chk_level(thresh_cfg))); // R6

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> ((pop_data == '0) && (pop_stat == '0))); // R4

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count == '0) && pop_req && !rx_valid) |=> (fill_count == '0)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(fill_count) == DEPTH) && rx_valid && !pop_req) |=> (int'(fill_count) == DEPTH)); // R7

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count != '0) && rx_valid && pop_req) |=> $stable(fill_count)); // R3
endmodule

bind rxq_fifo rxq_chk #(
    .DEPTH (DEPTH),
    .TH_W  (TH_W),
    .DW    (rxq_pkg::DATA_W),
    .SW    (rxq_pkg::STAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .pop_req    (pop_req),
    .thresh_cfg (thresh_cfg),
    .fill_count (fill_count),
    .svc_req    (svc_req),
    .pop_data   (pop_data),
    .pop_stat   (pop_stat)
);

// File: tb/tb_rxq_fifo.sv
module tb_rxq_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic [3:0] thresh_cfg = 4'd4;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [3:0] pop_stat;
    logic [3:0] fill_count;
    logic       svc_req;

    int checks = 0;
    int failures = 0;

    logic [7:0] md [D];
    logic [3:0] ms [D];
    int         mcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .thresh_cfg(thresh_cfg), .pop_req(pop_req),
        .pop_data(pop_data), .pop_stat(pop_stat), .fill_count(fill_count),
        .svc_req(svc_req)
    );

    function automatic int exp_level(input int c);
        return ((c == 0) || (c > D)) ? D : c;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R3 count", int'(fill_count), mcount);
        check("R6 svc_req", int'(svc_req), (mcount >= exp_level(int'(thresh_cfg))) ? 1 : 0);
        if (mcount == 0) begin
            check("R4 empty data", int'(pop_data), 0);
            check("R4 empty stat", int'(pop_stat), 0);
        end else begin
            check("R2 head data", int'(pop_data), int'(md[0]));
            check("R2 head stat", int'(pop_stat), int'(ms[0]));
        end
    endtask

    // drive one cycle starting at a negedge, predict, then check at the next negedge
    task automatic cyc(input logic pv, input logic [7:0] d, input logic [2:0] e, input logic pr);
        bit dp, dpush, ovr;
        rx_valid = pv; rx_data = d; rx_err = e; pop_req = pr;
        dp    = pr && (mcount != 0);
        dpush = pv && ((mcount < D) || dp);
        ovr   = pv && (mcount == D) && !dp;
        if (dp) begin
            for (int i = 0; i < D - 1; i++) begin
                md[i] = md[i+1];
                ms[i] = ms[i+1];
            end
            mcount--;
        end
        if (dpush) begin
            md[mcount] = d;
            ms[mcount] = {1'b0, e};
            mcount++;
        end
        if (ovr) ms[D-1][3] = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; pop_req = 1'b0;
        check_all();
    endtask

    task automatic drain();
        while (mcount != 0) cyc(1'b0, 8'h00, 3'b000, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1d5e7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", int'(fill_count), 0);
        check("R1 svc_req", int'(svc_req), 0);
        check("R1 data", int'(pop_data), 0);
        check("R1 stat", int'(pop_stat), 0);

        // R4 pop on empty
        cyc(1'b0, 8'h00, 3'b000, 1'b1);
        check("R4 empty pop count", int'(fill_count), 0);

        // R5 clamp: cfg 0 behaves as 8
        thresh_cfg = 4'd0;
        for (int i = 0; i < 7; i++) cyc(1'b1, 8'(8'h10 + i), 3'(i), 1'b0);
        check("R5 cfg0 at 7", int'(svc_req), 0);
        cyc(1'b1, 8'h17, 3'b101, 1'b0);
        check("R5 cfg0 at 8", int'(svc_req), 1);
        thresh_cfg = 4'd9;
        #1 check("R5 cfg9 at 8", int'(svc_req), 1);
        thresh_cfg = 4'd15;
        #1 check("R5 cfg15 at 8", int'(svc_req), 1);

        // R9 full with simultaneous push and pop
        cyc(1'b1, 8'h5A, 3'b011, 1'b1);
        check("R9 count", int'(fill_count), 8);
        check("R9 no overrun", int'(pop_stat[3]), 0);

        // R7 drop while full
        cyc(1'b1, 8'hAA, 3'b111, 1'b0);
        check("R7 count", int'(fill_count), 8);
        cyc(1'b1, 8'hBB, 3'b111, 1'b0);
        check("R7 count again", int'(fill_count), 8);

        // R6 fall below threshold on pop
        cyc(1'b0, 8'h00, 3'b000, 1'b1);
        check("R6 svc fell", int'(svc_req), 0);

        // R8 overrun only on newest entry
        while (mcount > 1) begin
            check("R8 older clear", int'(pop_stat[3]), 0);
            cyc(1'b0, 8'h00, 3'b000, 1'b1);
        end
        check("R8 newest flagged", int'(pop_stat[3]), 1);
        check("R8 newest data", int'(pop_data), 8'h5A);
        cyc(1'b0, 8'h00, 3'b000, 1'b1);
        cyc(1'b1, 8'h33, 3'b000, 1'b0);
        check("R8 cleared on reuse", int'(pop_stat[3]), 0);
        drain();

        // R6 directed threshold 3
        thresh_cfg = 4'd3;
        cyc(1'b1, 8'h01, 3'b000, 1'b0);
        cyc(1'b1, 8'h02, 3'b000, 1'b0);
        check("R6 below", int'(svc_req), 0);
        cyc(1'b1, 8'h03, 3'b000, 1'b0);
        check("R6 reached", int'(svc_req), 1);
        drain();

        // random phases: fill-biased, drain-biased, balanced
        for (int ph = 0; ph < 6; ph++) begin
            int pw, pp;
            thresh_cfg = 4'($urandom_range(0, 15));
            pw = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
            pp = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 75 : 50;
            for (int n = 0; n < 400; n++) begin
                cyc(logic'($urandom_range(0, 99) < pw), 8'($urandom),
                    3'($urandom), logic'($urandom_range(0, 99) < pp));
            end
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule